// File: doc/BRIEF.md
# Grouped-Interrupt GPIO Bank

A bank of general-purpose pins behind a word-wide register port. Every pin owns one 32-bit word that holds its drive controls, shows its synchronized input level, and configures an interrupt detector: edge or level, high/rising, low/falling, or both edges, gated by a detect-enable bit and a forward-mask bit. Detection sets a sticky status bit that software clears by writing the word back.

A summary view folds the pin status bits four at a time, so an interrupt handler reads two words to find which groups of pins need attention. All forwarded status bits merge into one interrupt line. Writing the end-of-interrupt bit in the master word forces that line low for one cycle, so a source still pending afterwards shows up as a fresh assertion.

The request side is valid/ready. `req_ready` is always high, so a request is taken in the cycle `req_valid` is high and the bank never applies back-pressure. A read answers with `rsp_valid` and `rsp_rdata` one cycle later. The response side has no ready and cannot be stalled.

Top module: `gpio_bank`

## Requirements
- R1: Pin n's word is at byte offset 4n for n below NUM_PINS (184). The exceptions are offset 0xFC, which is the master word, and any offset with address bits 1:0 not zero. Reads of the master word and of unmapped offsets return zero. Every read returns its data with `rsp_valid` one cycle after the request.
- R2: Word bits 8 (level mode), 9 (low/falling), 10 (both edges), 11 (detect enable), 12 (forward mask), 22 (output value) and 23 (output enable) take the written value and read back. Every other bit ignores writes. `pad_out[n]` follows bit 22 and `pad_oe[n]` follows bit 23.
- R3: Bit 16 reads the pin input through a two-flop synchronizer. It shows a new level at most three clocks after the pad changes.
- R4: With bit 8 clear (edge mode) and bit 11 set, status bit 28 sets on a rising edge when bits 10:9 are 00, on a falling edge when bit 9 is set and bit 10 is clear, and on either edge when bit 10 is set.
- R5: With bit 8 set (level mode) and bit 11 set, status sets while the input is high (bit 9 clear) or low (bit 9 set). Bit 10 is ignored in level mode. Status stays set after the level goes inactive.
- R6: Writing a word with bit 28 set clears its status. Writing 0 there leaves the status unchanged. If detection sets the status in the same cycle as the clear, the set wins, so a clear during an active level has no effect.
- R7: With bit 11 clear, no input activity sets status.
- R8: Summary bit i is the OR of the status bits of pins 4i to 4i+3, regardless of the mask bit. Bits 0-31 read at 0x2F8 and bits 32-45 at 0x2FC, with the upper bits zero.
- R9: `irq` goes high one clock after any pin has status, bit 11 and bit 12 all set. It goes low one clock after no pin does.
- R10: Writing 0xFC with bit 29 set forces `irq` low in the following cycle. If a source is still pending, `irq` re-asserts one cycle after that.
- R11: Pin 63, whose slot is taken by the master word, never raises status, has no readable word and does not drive its pad.
- R12: After reset, all words, status bits, summary bits, pad outputs and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pad_in | input | NUM_PINS | pin input levels |
| pad_out | output | NUM_PINS | pin output values |
| pad_oe | output | NUM_PINS | pin output enables |
| req_valid | input | 1 | register request present |
| req_ready | output | 1 | request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | byte offset |
| req_wdata | input | 32 | write data |
| rsp_valid | output | 1 | read data valid |
| rsp_rdata | output | 32 | read data |
| irq | output | 1 | combined interrupt |

## Verification
The bench sweeps every pin through config writes with junk in non-writable bits, input-level reads and reset reads. A wrong writable mask or a bad address decode shows up as a mismatched word or a wrongly driven pad. Each edge polarity is exercised on pins at group boundaries: 0, 5, 62 and 64 (either side of the hole) and 183 (the last pin). A swapped edge sense sets status on the wrong transition, and a wrong grouping lights the wrong summary bit. Level mode checks that a write-back during an active level leaves status set. A design where the clear beats detection would drop a still-active request. The end-of-interrupt cycle is sampled exactly: a design that ignores it keeps `irq` high, and one that latches it low never re-asserts. Pin 63 toggling must leave status, summary and `irq` untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W  = 32;
  localparam int B_LEVEL = 8;
  localparam int B_ACTLO = 9;
  localparam int B_BOTH  = 10;
  localparam int B_IEN   = 11;
  localparam int B_IMASK = 12;
  localparam int B_RX    = 16;
  localparam int B_TXV   = 22;
  localparam int B_TXE   = 23;
  localparam int B_STS   = 28;
  localparam int B_EOI   = 29;

  typedef struct packed {
    logic level;
    logic actlo;
    logic both;
    logic ien;
    logic imask;
    logic txv;
    logic txe;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
#(
  parameter bit IRQ_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  input  logic              wr_en,
  input  pin_cfg_t          wr_cfg,
  input  logic              wr_clr,
  output logic [WORD_W-1:0] word,
  output logic              sts_o,
  output logic              pend_o,
  output logic              pad_out,
  output logic              pad_oe
);
  logic     s1, s2, s3;
  logic     sts, hit, sts_next;
  pin_cfg_t cfg;

  always_comb begin
    if (cfg.level)     hit = cfg.actlo ? ~s2 : s2;
    else if (cfg.both) hit = s2 ^ s3;
    else if (cfg.actlo) hit = ~s2 & s3;
    else               hit = s2 & ~s3;
    sts_next = IRQ_CAPABLE && ((cfg.ien && hit) || (sts && !(wr_en && wr_clr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      cfg <= '0;
      sts <= 1'b0;
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      sts <= sts_next;
      if (wr_en) cfg <= wr_cfg;
    end
  end

  always_comb begin
    word          = '0;
    word[B_LEVEL] = cfg.level;
    word[B_ACTLO] = cfg.actlo;
    word[B_BOTH]  = cfg.both;
    word[B_IEN]   = cfg.ien;
    word[B_IMASK] = cfg.imask;
    word[B_RX]    = s2;
    word[B_TXV]   = cfg.txv;
    word[B_TXE]   = cfg.txe;
    word[B_STS]   = sts;
  end

  assign sts_o   = sts;
  assign pend_o  = sts & cfg.ien & cfg.imask;
  assign pad_out = cfg.txv;
  assign pad_oe  = cfg.txe;
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate #(
  parameter int NUM_PINS = 184,
  parameter int GROUP    = 4,
  localparam int NUM_SUM = (NUM_PINS + GROUP - 1) / GROUP,
  localparam int PADDED  = NUM_SUM * GROUP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PINS-1:0] sts_vec,
  input  logic [NUM_PINS-1:0] pend_vec,
  input  logic               eoi_wr,
  output logic [NUM_SUM-1:0] summary,
  output logic               irq
);
  logic [PADDED-1:0] sts_pad;

  always_comb begin
    sts_pad = '0;
    sts_pad[NUM_PINS-1:0] = sts_vec;
  end

  for (genvar g = 0; g < NUM_SUM; g++) begin : g_grp
    assign summary[g] = |sts_pad[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (eoi_wr) irq <= 1'b0;
    else             irq <= |pend_vec;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 184,
  parameter int GROUP      = 4,
  parameter int ADDR_W     = 12,
  parameter int MASTER_OFS = 'h0FC,
  parameter int SUM_OFS    = 'h2F8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                irq
);
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int PIN_IDX_W = $clog2(NUM_PINS);
  localparam int NUM_SUM   = (NUM_PINS + GROUP - 1) / GROUP;
  localparam int HOLE      = MASTER_OFS / 4;

  logic [WIDX_W-1:0]   word_idx;
  logic                is_pin, is_sum_lo, is_sum_hi, is_master, eoi_wr;
  logic [NUM_PINS-1:0] sts_vec, pend_vec, wr_sel;
  logic [WORD_W-1:0]   words [NUM_PINS];
  logic [NUM_SUM-1:0]  summary;
  logic [63:0]         sum_flat;
  logic [WORD_W-1:0]   rd_mux;
  pin_cfg_t            wr_cfg;

  assign req_ready = 1'b1;
  assign word_idx  = req_addr[ADDR_W-1:2];
  assign is_pin    = (req_addr[1:0] == 2'b00) && (word_idx < WIDX_W'(NUM_PINS))
                     && (word_idx != WIDX_W'(HOLE));
  assign is_sum_lo = (req_addr == ADDR_W'(SUM_OFS));
  assign is_sum_hi = (req_addr == ADDR_W'(SUM_OFS + 4));
  assign is_master = (req_addr == ADDR_W'(MASTER_OFS));
  assign eoi_wr    = req_valid && req_write && is_master && req_wdata[B_EOI];

  assign wr_cfg = '{level: req_wdata[B_LEVEL], actlo: req_wdata[B_ACTLO],
                    both: req_wdata[B_BOTH], ien: req_wdata[B_IEN],
                    imask: req_wdata[B_IMASK], txv: req_wdata[B_TXV],
                    txe: req_wdata[B_TXE]};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == HOLE) begin : g_hole
      assign wr_sel[p] = 1'b0;
      gpio_pin_cell #(.IRQ_CAPABLE(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in[p]), .wr_en(wr_sel[p]),
        .wr_cfg(wr_cfg), .wr_clr(req_wdata[B_STS]), .word(words[p]),
        .sts_o(sts_vec[p]), .pend_o(pend_vec[p]),
        .pad_out(pad_out[p]), .pad_oe(pad_oe[p]));
    end else begin : g_norm
      assign wr_sel[p] = req_valid && req_write && is_pin && (word_idx == WIDX_W'(p));
      gpio_pin_cell #(.IRQ_CAPABLE(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in[p]), .wr_en(wr_sel[p]),
        .wr_cfg(wr_cfg), .wr_clr(req_wdata[B_STS]), .word(words[p]),
        .sts_o(sts_vec[p]), .pend_o(pend_vec[p]),
        .pad_out(pad_out[p]), .pad_oe(pad_oe[p]));
    end
  end

  gpio_irq_gate #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_gate (
    .clk(clk), .rst_n(rst_n), .sts_vec(sts_vec), .pend_vec(pend_vec),
    .eoi_wr(eoi_wr), .summary(summary), .irq(irq));

  always_comb begin
    sum_flat = '0;
    sum_flat[NUM_SUM-1:0] = summary;
    rd_mux = '0;
    if (is_pin)         rd_mux = words[word_idx[PIN_IDX_W-1:0]];
    else if (is_sum_lo) rd_mux = sum_flat[31:0];
    else if (is_sum_hi) rd_mux = sum_flat[63:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS   = 184,
  parameter int ADDR_W     = 12,
  parameter int MASTER_OFS = 'h0FC
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                eoi_bit,
  input logic                rsp_valid,
  input logic                irq,
  input logic [NUM_PINS-1:0] sts_vec,
  input logic [NUM_PINS-1:0] pend_vec
);
  localparam int HOLE = MASTER_OFS / 4;

  // R1
  rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R1
  rsp_only_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R10
  eoi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(MASTER_OFS) && eoi_bit) |=> !irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|pend_vec));

  // R11
  hole_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_vec[HOLE]);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MASTER_OFS(MASTER_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .eoi_bit(req_wdata[29]), .rsp_valid(rsp_valid),
  .irq(irq), .sts_vec(sts_vec), .pend_vec(pend_vec));

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(a);
    @(negedge clk);
    if (rsp_valid !== 1'b1) chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_of(input int p);
    logic [31:0] w = '0;
    w[8] = p[0]; w[9] = p[1]; w[10] = p[2]; w[12] = p[3]; w[22] = p[4]; w[23] = p[5];
    return w;
  endfunction

  function automatic int sum_addr(input int p);
    return (p / 4 < 32) ? 'h2F8 : 'h2FC;
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic clear_pin(input int p);
    logic [31:0] v;
    rd(4 * p, v);
    wr(4 * p, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int pins[5] = '{0, 5, 62, 64, 183};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state over every pin word and register
    chk("R12 irq", {31'b0, irq}, 0);
    chk("R12 pad_oe", {31'b0, |pad_oe}, 0);
    for (int p = 0; p < NP; p++) begin rd(4 * p, v); chk("R12 word", v, 0); end
    rd('h2F8, v); chk("R12 sum lo", v, 0);
    rd('h2FC, v); chk("R12 sum hi", v, 0);

    // R2 writable bits, junk in other bits, pad outputs
    for (int p = 0; p < NP; p++) wr(4 * p, cfg_of(p) | 32'hFF3FE0FF);
    for (int p = 0; p < NP; p++) begin
      rd(4 * p, v);
      if (p == 63) begin
        chk("R11 hole word", v, 0);
        chk("R11 hole pad", {30'b0, pad_out[p], pad_oe[p]}, 0);
      end else begin
        chk("R2 word", v, cfg_of(p));
        chk("R2 pads", {30'b0, pad_out[p], pad_oe[p]}, {30'b0, cfg_of(p)[22], cfg_of(p)[23]});
      end
    end
    for (int p = 0; p < NP; p++) wr(4 * p, 0);

    // R3 synchronized input level
    for (int p = 0; p < NP; p++) pad_in[p] = (p % 3 == 0);
    idle(3);
    for (int p = 0; p < NP; p++) begin
      rd(4 * p, v);
      chk("R3 rx level", v, (p % 3 == 0 && p != 63) ? 32'h0001_0000 : 32'h0);
    end
    pad_in = '0;
    idle(3);

    // R4 R8 R9 R6 edge modes on group-boundary pins
    for (int m = 0; m < 3; m++) begin
      foreach (pins[k]) begin
        automatic int p = pins[k];
        automatic logic [31:0] c = 32'h1800 | (m == 1 ? 32'h200 : 0) | (m == 2 ? 32'h400 : 0);
        automatic bit on_rise = (m != 1);
        automatic bit on_fall = (m != 0);
        wr(4 * p, c);
        pad_in[p] = 1'b1; idle(5);
        rd(4 * p, v); chk("R4 rise sts", {31'b0, v[28]}, {31'b0, on_rise});
        rd(sum_addr(p), v); chk("R8 summary", {31'b0, v[(p / 4) % 32]}, {31'b0, on_rise});
        chk("R9 irq", {31'b0, irq}, {31'b0, on_rise});
        clear_pin(p); idle(2);
        rd(4 * p, v); chk("R6 cleared", {31'b0, v[28]}, 0);
        chk("R9 irq drop", {31'b0, irq}, 0);
        pad_in[p] = 1'b0; idle(5);
        rd(4 * p, v); chk("R4 fall sts", {31'b0, v[28]}, {31'b0, on_fall});
        clear_pin(p);
        wr(4 * p, 0);
      end
    end

    // R5 R6 level high: clear during active level has no effect
    wr(40, 32'h1D00);
    pad_in[10] = 1'b1; idle(5);
    rd(40, v); chk("R5 level set", {31'b0, v[28]}, 1);
    chk("R9 level irq", {31'b0, irq}, 1);
    clear_pin(10);
    rd(40, v); chk("R6 set beats clear", {31'b0, v[28]}, 1);
    pad_in[10] = 1'b0; idle(5);
    rd(40, v); chk("R5 sticky", {31'b0, v[28]}, 1);
    clear_pin(10); idle(2);
    rd(40, v); chk("R6 level cleared", {31'b0, v[28]}, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(40, 0);

    // R5 level low
    pad_in[11] = 1'b1; idle(4);
    wr(44, 32'h1B00); idle(3);
    rd(44, v); chk("R5 low idle", {31'b0, v[28]}, 0);
    pad_in[11] = 1'b0; idle(5);
    rd(44, v); chk("R5 low active", {31'b0, v[28]}, 1);
    wr(44, 0); clear_pin(11);
    rd(44, v); chk("R5 low cleared", {31'b0, v[28]}, 0);

    // R8 R9 mask clear: status and summary but no irq
    wr(80, 32'h0800);
    pad_in[20] = 1'b1; idle(5);
    rd(80, v); chk("R8 masked sts", {31'b0, v[28]}, 1);
    rd('h2F8, v); chk("R8 masked summary", v, 32'h20);
    chk("R9 masked irq", {31'b0, irq}, 0);
    clear_pin(20); wr(80, 0); pad_in[20] = 1'b0;

    // R7 detect disabled
    wr(84, 32'h1000);
    pad_in[21] = 1'b1; idle(5);
    rd(84, v); chk("R7 no detect", {31'b0, v[28]}, 0);
    chk("R7 irq", {31'b0, irq}, 0);
    pad_in[21] = 1'b0; wr(84, 0); idle(4);

    // R10 end of interrupt
    wr(120, 32'h1800);
    pad_in[30] = 1'b1; idle(5);
    chk("R10 pre irq", {31'b0, irq}, 1);
    wr('hFC, 32'h2000_0000);
    chk("R10 eoi low", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 re-assert", {31'b0, irq}, 1);
    rd('hFC, v); chk("R10 master reads 0", v, 0);
    clear_pin(30); wr(120, 0); pad_in[30] = 1'b0; idle(3);

    // R11 pin 63 silent, master write does not configure it
    wr('hFC, 32'h00C0_1800);
    pad_in[63] = 1'b1; idle(5);
    pad_in[63] = 1'b0; idle(5);
    rd('hFC, v); chk("R11 hole read", v, 0);
    rd('h2F8, v); chk("R11 hole summary", v, 0);
    chk("R11 hole irq", {31'b0, irq}, 0);
    chk("R11 hole pads", {30'b0, pad_out[63], pad_oe[63]}, 0);

    // R1 unmapped offsets
    wr(4 * NP, 32'hFFFF_FFFF);
    rd(4 * NP, v); chk("R1 past last pin", v, 0);
    rd('h300, v); chk("R1 beyond summary", v, 0);
    pad_in[1] = 1'b1; idle(3);
    rd(5, v); chk("R1 unaligned", v, 0);
    rd(4, v); chk("R1 aligned", v, 32'h0001_0000);
    chk("R1 ready", {31'b0, req_ready}, 1);

    finish_run();
  end
endmodule